// File: doc/BRIEF.md
# FIFO-Style Byte Bus Master

This block moves compressed data, one byte at a time, between an internal data path and an external memory that behaves as a FIFO. It is the bus master on an 8-bit tri-state data bus. It produces no address. Instead, an active-low address-advance strobe marks each access, so the memory's own control logic can step a counter. The internal side sees a byte stream with valid/ready, an enable bit, a direction select and a 3-bit cycle-length field.

A bus cycle lasts between one and eight clocks. Chip select is low for the whole cycle. The read or write strobe goes low half a clock after the cycle begins and stays low until the cycle ends. The memory can hold off accesses with a busy input. Busy is taken at the rising edge one clock before a cycle would begin. When the bus is free, the block is enabled, the internal side can supply or take a byte, and busy was low at that earlier edge, a new cycle starts. It can start in the clock right after the previous cycle ends, with chip select staying low across the boundary.

Top module: `fifo_byte_master`

## Requirements
- R1: While reset is held, and whenever no cycle is running, `busCsN`, `busOeN`, `busWeN` and `busAdvN` are high, `rxValid` is low and the block does not drive `busData`.
- R2: A cycle keeps `busCsN` low for exactly `cycLen`+1 clocks (field value 0 gives 1 clock, 7 gives 8 clocks). The field and `dirWrite` are taken at the cycle's start edge.
- R3: A cycle starts at rising edge k only if `memBusy` was low at rising edge k-1. When the bus is free at edge k and the request of R10 holds there, a cycle does start.
- R4: A new cycle may begin at the edge that ends the previous one. In back-to-back cycles `busCsN` stays low with no gap.
- R5: `busAdvN` is low during exactly the last clock of each cycle and at no other time.
- R6: In a read cycle (`dirWrite`=0), `busOeN` goes low at the falling edge inside the first clock and stays low until the cycle's final rising edge. `busWeN` stays high and the block does not drive `busData`.
- R7: The read byte is the `busData` value at the rising edge that ends the cycle. It appears on `rxData` with `rxValid` high for exactly the one clock after that edge.
- R8: In a write cycle (`dirWrite`=1), `busWeN` goes low at the falling edge inside the first clock and stays low until the cycle ends. `busOeN` stays high. The block drives the accepted byte on `busData` during every clock of the cycle.
- R9: `txReady` is high exactly in the clock before a write cycle's start edge. The byte on `txData` at that edge is the one carried by that cycle.
- R10: A cycle is requested only when `enable` is high and, for writes, `txValid` is high or, for reads, `rxReady` is high. With `enable` low no cycle starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active; the falling edge times the half-clock strobes |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Allows new bus cycles to start |
| dirWrite | input | 1 | 1 = write cycles (encoding), 0 = read cycles (decoding) |
| cycLen | input | 3 | Cycle length minus one, in clocks |
| txData | input | 8 | Byte to be written |
| txValid | input | 1 | `txData` holds a byte |
| txReady | output | 1 | Byte on `txData` is taken at this rising edge |
| rxData | output | 8 | Byte read from the bus |
| rxValid | output | 1 | One-clock pulse marking a new `rxData` |
| rxReady | input | 1 | Internal side can take a byte at the end of the next read cycle |
| memBusy | input | 1 | Memory busy; suppresses the next cycle start |
| busData | inout | 8 | External data bus, tri-state |
| busCsN | output | 1 | Chip select, active low |
| busOeN | output | 1 | Output enable for reads, active low |
| busWeN | output | 1 | Write enable, active low |
| busAdvN | output | 1 | Address-advance strobe, active low, last clock of each cycle |

## Verification
Every cycle length from 1 to 8 clocks is run in both directions with `memBusy` held low. Here cycles must run back to back, and the cycle count over a fixed window must match the arithmetic value, which separates correct turnaround from a lost or extra clock between cycles. The same sweep is then repeated with a periodic busy pattern, where the bench recomputes the start rule every clock from the busy level at the previous edge. This catches a sample taken one edge early or late, and a start suppressed at the wrong time. Runs that toggle `txValid` or `rxReady`, and one with `enable` held low, show that the internal side gates cycle starts. Ramp byte patterns on both sides show that data is taken at the correct edge and that each byte is carried exactly once.

// File: rtl/fbm_pkg.sv
package fbm_pkg;

  // Strobes sent from the bus sequencer to the byte datapath
  typedef struct packed {
    logic loadTx;     // take the outgoing byte at this edge
    logic captureRx;  // take the bus byte at this edge (read cycle end)
    logic driveBus;   // a write cycle is running: drive the data bus
  } fbmStrobe_t;

  localparam int unsigned FBM_DATA_W = 8;
  localparam int unsigned FBM_LEN_W  = 3;

endpackage

// File: rtl/fbm_ctrl.sv
module fbm_ctrl
  import fbm_pkg::*;
#(
  parameter int unsigned LEN_W = FBM_LEN_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             dirWrite,
  input  logic [LEN_W-1:0] cycLen,
  input  logic             txValid,
  input  logic             rxReady,
  input  logic             memBusy,
  output fbmStrobe_t       strb,
  output logic             txReady,
  output logic             busCsN,
  output logic             busOeN,
  output logic             busWeN,
  output logic             busAdvN
);

  localparam logic [LEN_W-1:0] CNT_ONE = LEN_W'(1);

  logic             busyQ;
  logic             cycActive;
  logic             cycWrite;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] lenQ;
  logic             togRise;
  logic             togFall;
  logic             lastClk;
  logic             busFree;
  logic             wantCycle;
  logic             startNow;
  logic             strobeOn;

  assign lastClk   = cycActive && (cnt == lenQ);
  assign busFree   = !cycActive || lastClk;
  assign wantCycle = enable && (dirWrite ? txValid : rxReady);
  assign startNow  = busFree && wantCycle && !busyQ;

  // Rising-edge state: busy sample, cycle tracking, start toggle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ     <= 1'b1;
      cycActive <= 1'b0;
      cycWrite  <= 1'b0;
      cnt       <= '0;
      lenQ      <= '0;
      togRise   <= 1'b0;
    end else begin
      busyQ <= memBusy;
      if (startNow) begin
        cycActive <= 1'b1;
        cycWrite  <= dirWrite;
        lenQ      <= cycLen;
        cnt       <= '0;
        togRise   <= ~togRise;
      end else if (lastClk) begin
        cycActive <= 1'b0;
        cnt       <= '0;
      end else if (cycActive) begin
        cnt <= cnt + CNT_ONE;
      end
    end
  end

  // Falling-edge copy of the start toggle: the two differ only in the
  // first half clock of each cycle, which holds the strobe off there
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      togFall <= 1'b0;
    end else begin
      togFall <= togRise;
    end
  end

  assign strobeOn = cycActive && (togRise == togFall);

  assign busCsN  = !cycActive;
  assign busAdvN = !lastClk;
  assign busOeN  = !(strobeOn && !cycWrite);
  assign busWeN  = !(strobeOn && cycWrite);

  assign strb.loadTx    = startNow && dirWrite;
  assign strb.captureRx = lastClk && !cycWrite;
  assign strb.driveBus  = cycActive && cycWrite;

  assign txReady = strb.loadTx;

endmodule

// File: rtl/fbm_datapath.sv
module fbm_datapath
  import fbm_pkg::*;
#(
  parameter int unsigned DATA_W = FBM_DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  fbmStrobe_t        strb,
  input  logic [DATA_W-1:0] txData,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] wrByte,
  output logic              busDrive,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrByte  <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      if (strb.loadTx) begin
        wrByte <= txData;
      end
      rxValid <= strb.captureRx;
      if (strb.captureRx) begin
        rxData <= busIn;
      end
    end
  end

  assign busDrive = strb.driveBus;

endmodule

// File: rtl/fifo_byte_master.sv
module fifo_byte_master
  import fbm_pkg::*;
#(
  parameter int unsigned DATA_W = FBM_DATA_W,
  parameter int unsigned LEN_W  = FBM_LEN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              dirWrite,
  input  logic [LEN_W-1:0]  cycLen,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  input  logic              memBusy,
  inout  wire  [DATA_W-1:0] busData,
  output logic              busCsN,
  output logic              busOeN,
  output logic              busWeN,
  output logic              busAdvN
);

  fbmStrobe_t        strb;
  logic [DATA_W-1:0] wrByte;
  logic              busDrive;

  fbm_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .dirWrite (dirWrite),
    .cycLen   (cycLen),
    .txValid  (txValid),
    .rxReady  (rxReady),
    .memBusy  (memBusy),
    .strb     (strb),
    .txReady  (txReady),
    .busCsN   (busCsN),
    .busOeN   (busOeN),
    .busWeN   (busWeN),
    .busAdvN  (busAdvN)
  );

  fbm_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .txData   (txData),
    .busIn    (busData),
    .wrByte   (wrByte),
    .busDrive (busDrive),
    .rxData   (rxData),
    .rxValid  (rxValid)
  );

  assign busData = busDrive ? wrByte : {DATA_W{1'bz}};

endmodule

// File: rtl/fbm_checker.sv
module fbm_checker (
  input logic clk,
  input logic rstN,
  input logic memBusy,
  input logic txReady,
  input logic rxValid,
  input logic busCsN,
  input logic busOeN,
  input logic busWeN,
  input logic busAdvN
);

  // R1: outside a cycle every control strobe is inactive
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    busCsN |-> (busOeN && busWeN && busAdvN));

  // R5: the advance strobe only appears inside a cycle
  p_adv_in_cycle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busAdvN |-> !busCsN);

  // R3: a cycle begins only if busy was low one edge before its start
  p_busy_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busCsN && ($past(busCsN) || !$past(busAdvN))) |-> !$past(memBusy, 2));

  // R6: read and write strobes never overlap
  p_one_dir_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busOeN |-> busWeN);

  // R7: a read byte is presented right after a read cycle's last clock
  p_rx_after_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (!$past(busAdvN) && !$past(busOeN)));

  // R9: accepting a byte is followed by a write cycle
  p_tx_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    txReady |=> (!busCsN && !busWeN));

endmodule

bind fifo_byte_master fbm_checker chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .memBusy (memBusy),
  .txReady (txReady),
  .rxValid (rxValid),
  .busCsN  (busCsN),
  .busOeN  (busOeN),
  .busWeN  (busWeN),
  .busAdvN (busAdvN)
);

// File: tb/fifo_byte_master_tb_top.sv
`timescale 1ns/1ps
module fifo_byte_master_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       dirWrite = 1'b0;
  logic [2:0] cycLen = 3'd0;
  logic [7:0] txData;
  logic       txValid = 1'b0;
  logic       txReady;
  logic [7:0] rxData;
  logic       rxValid;
  logic       rxReady = 1'b0;
  logic       memBusy = 1'b0;
  wire  [7:0] busData;
  logic       busCsN, busOeN, busWeN, busAdvN;

  always #4 clk = ~clk;

  fifo_byte_master dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .dirWrite(dirWrite),
    .cycLen(cycLen), .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady), .memBusy(memBusy),
    .busData(busData), .busCsN(busCsN), .busOeN(busOeN), .busWeN(busWeN),
    .busAdvN(busAdvN)
  );

  int nChecks = 0;
  int nFail = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] wrPat(input int n);
    return 8'((n * 53 + 5) % 256);
  endfunction

  function automatic logic [7:0] rdPat(input int n);
    return 8'((n * 37 + 11) % 256);
  endfunction

  // Source, FIFO memory model and counters
  int txIdx = 0;
  int rdPtr = 0;
  int wrCnt = 0;
  int rxCnt = 0;

  assign txData  = wrPat(txIdx);
  assign busData = (!busOeN) ? rdPat(rdPtr) : 8'bz;

  always @(posedge clk) begin
    if (txReady && txValid) txIdx <= txIdx + 1;
    if (!busAdvN && !busOeN) rdPtr <= rdPtr + 1;
    if (!busAdvN && !busWeN) wrCnt <= wrCnt + 1;
  end

  // Monitor: samples 2 ns and 6 ns after each rising edge
  bit monOn = 1'b0;
  int expL = 1;
  bit expWrite = 1'b0;
  int errStart = 0, errLen = 0, errStrobe = 0, errHand = 0, errData = 0;
  int cycCount = 0;

  initial begin
    bit prevCs = 1'b0, prevAdv = 1'b0, prevBusy = 1'b1, prevTxRdy = 1'b0;
    int pos = 0;
    forever begin
      @(posedge clk);
      #2;
      if (monOn) begin
        bit csLow, advLow, freeBus, wantNow, expStart, first, actS, othS;
        csLow    = !busCsN;
        advLow   = !busAdvN;
        freeBus  = !prevCs || prevAdv;
        wantNow  = enable && (dirWrite ? txValid : rxReady);
        expStart = freeBus && wantNow && !prevBusy;
        if (freeBus && (csLow != expStart)) errStart++;
        first = csLow && freeBus;
        if (first) pos = 0;
        else if (csLow) pos++;
        if (csLow) begin
          if (advLow != (pos == expL - 1)) errLen++;
          if (advLow) cycCount++;
        end else if (advLow) errLen++;
        actS = expWrite ? busWeN : busOeN;
        othS = expWrite ? busOeN : busWeN;
        if (csLow) begin
          if (actS != first) errStrobe++;
          if (!othS) errStrobe++;
        end else if (!busOeN || !busWeN) errStrobe++;
        if (prevTxRdy != (first && expWrite)) errHand++;
        if (rxValid != (prevAdv && !expWrite)) errHand++;
        if (rxValid) begin
          if (rxData != rdPat(rxCnt)) errData++;
          rxCnt++;
        end
        if (csLow && expWrite && (busData != wrPat(wrCnt))) errData++;
        prevCs = csLow;
        prevAdv = advLow;
        prevBusy = memBusy;
      end
      #4;
      if (monOn) begin
        if (!busCsN) begin
          if ((expWrite ? busWeN : busOeN) != 1'b0) errStrobe++;
          if ((expWrite ? busOeN : busWeN) != 1'b1) errStrobe++;
          if (expWrite && (busData != wrPat(wrCnt))) errData++;
        end
        prevTxRdy = txReady;
      end
    end
  end

  task automatic clearErr();
    errStart = 0; errLen = 0; errStrobe = 0; errHand = 0; errData = 0;
  endtask

  // One run: fixed direction and length, optional busy and stall patterns
  task automatic runCase(input bit wr, input int len, input int busyMod, input int stallMod);
    int c0, d0;
    @(negedge clk);
    enable = 1'b0;
    memBusy = 1'b0;
    repeat (12) @(negedge clk);
    dirWrite = wr;
    cycLen = 3'(len - 1);
    expWrite = wr;
    expL = len;
    txValid = wr;
    rxReady = !wr;
    clearErr();
    c0 = cycCount;
    d0 = wr ? wrCnt : rxCnt;
    enable = 1'b1;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      memBusy = (busyMod != 0) ? (((i * 7 + len) % busyMod) == 0) : 1'b0;
      if (wr) txValid = (stallMod != 0) ? ((i % stallMod) != 0) : 1'b1;
      else    rxReady = (stallMod != 0) ? ((i % stallMod) != 0) : 1'b1;
    end
    @(negedge clk);
    enable = 1'b0;
    memBusy = 1'b0;
    repeat (12) @(negedge clk);
    check(errStart == 0, "R3/R10 cycle start rule", errStart, 0);
    check(errLen == 0, "R2/R5 cycle length and advance strobe", errLen, 0);
    check(errStrobe == 0, wr ? "R8 write strobe timing" : "R6 read strobe timing", errStrobe, 0);
    check(errHand == 0, wr ? "R9 txReady timing" : "R7 rxValid timing", errHand, 0);
    check(errData == 0, wr ? "R8 write bus data" : "R7 read data", errData, 0);
    check(((wr ? wrCnt : rxCnt) - d0) == (cycCount - c0), "R7/R8 one byte per cycle",
          (wr ? wrCnt : rxCnt) - d0, cycCount - c0);
    if (busyMod == 0 && stallMod == 0)
      check((cycCount - c0) == (80 / len + 1), "R4 back-to-back cycle count",
            cycCount - c0, 80 / len + 1);
    else
      check((cycCount - c0) > 0, "R3 progress under busy/stall", cycCount - c0, 1);
  endtask

  initial begin
    #(8 * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int c0;
    // R1: outputs inactive during reset
    repeat (3) @(negedge clk);
    check(busCsN && busOeN && busWeN && busAdvN, "R1 strobes high in reset",
          {busCsN, busOeN, busWeN, busAdvN}, 15);
    check(!rxValid && !txReady, "R1 no handshake in reset", {rxValid, txReady}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(busCsN && busOeN && busWeN && busAdvN, "R1 strobes high after reset",
          {busCsN, busOeN, busWeN, busAdvN}, 15);
    monOn = 1'b1;

    // Sweep every length in both directions, busy-free and with busy
    for (int wr = 0; wr < 2; wr++) begin
      for (int len = 1; len <= 8; len++) begin
        runCase(wr[0], len, 0, 0);
        runCase(wr[0], len, 3, 0);
      end
    end

    // R10: internal-side stalls withhold starts
    runCase(1'b1, 2, 0, 3);
    runCase(1'b0, 3, 4, 2);
    runCase(1'b1, 1, 5, 4);
    runCase(1'b0, 1, 0, 2);

    // R10: with enable low nothing starts although data and memory are ready
    @(negedge clk);
    clearErr();
    c0 = cycCount;
    dirWrite = 1'b1;
    expWrite = 1'b1;
    txValid = 1'b1;
    rxReady = 1'b1;
    memBusy = 1'b0;
    repeat (40) @(negedge clk);
    check(cycCount == c0, "R10 no cycle while disabled", cycCount - c0, 0);
    check(busCsN && busWeN && busOeN && !txReady, "R10 idle while disabled",
          {busCsN, busWeN, busOeN, txReady}, 14);
    check(errStart == 0, "R10 start rule while disabled", errStart, 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule